// File: doc/BRIEF.md
# Caption Line Data Clock and Capture

This block captures one line of sliced closed-caption data. A start-bit detector outside the block reports a start bit with a single-cycle pulse. The block then waits a programmable number of reference clocks. After that it issues exactly sixteen data-clock enables, spaced by a programmable bit period. On each enable it shifts the comparator output into a sixteen-bit register, least significant bit first. The register is presented as a high byte and a low byte.

When the sixteenth enable has occurred, a latch-complete flag is raised. Under one start-bit method, the flag can also require that the external clock run-in pulse count lies inside the window 4 to 6. A two-bit selector picks the interrupt request source: end of line, capture finished, or capture finished with an acceptable run-in count. The request is raised at most once per line.

A falling edge on vertical sync clears the captured bytes, the flag and the sequencer, and re-arms the block for the next field. The block runs on the reference clock, so every delay below is counted in clock edges.

Top module: `cc_line_capture`

## Requirements
- R1: With `dly_sel` = N, the first `data_clk` pulse is registered on the 13+N-th clock edge after the edge that samples `start_det` high while idle.
- R2: Exactly 16 `data_clk` pulses follow per accepted start, each one cycle wide, consecutive pulses `bit_per` edges apart (`bit_per` = 0 behaves as 1); no further pulses occur until the next line.
- R3: On the edge that registers each `data_clk` pulse, `slice_bit` is shifted in at bit 15 and earlier bits move toward bit 0. After 16 pulses the first received bit sits in bit 0 of `byte_lo`; `byte_hi` holds bits 15..8 and `byte_lo` holds bits 7..0. The bytes do not change at any other time, except on a vertical sync clear.
- R4: When `method2` = 1 or `qual_en` = 0, `latch_done` rises together with the sixteenth pulse, whatever the run-in count.
- R5: When `method2` = 0 and `qual_en` = 1, `latch_done` rises with the sixteenth pulse only if `runin_cnt`, sampled on that edge, is 4, 5 or 6.
- R6: `irq` is a one-cycle pulse raised at most once per line. The source comes from `irq_sel`: 00 = `line_end` input, 01 = sixteenth pulse, 10 = sixteenth pulse with `runin_cnt` in 4..6, 11 = no request.
- R7: The edge that sees `vsync` low after it was high clears `byte_hi`, `byte_lo`, `latch_done`, `irq` and the sequencer. It also stops any capture in progress and re-arms start acceptance.
- R8: A `start_det` pulse during a capture, or after a completed capture, is ignored until the next vertical sync clear.
- R9: While `rst` is high, every output is zero at the following clock edge.
- R10: Once set, `latch_done` stays high until a vertical sync clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Vertical sync; its falling edge clears the block |
| start_det | input | 1 | Single-cycle start-bit detected pulse |
| slice_bit | input | 1 | Sliced comparator output |
| dly_sel | input | 5 | Start-to-first-clock delay N; wait is 13+N clocks |
| bit_per | input | 8 | Data-clock spacing in clocks (0 treated as 1) |
| method2 | input | 1 | 1 selects start-bit method 2 (no run-in qualification) |
| qual_en | input | 1 | Qualify the flag with the run-in window under method 1 |
| runin_cnt | input | 3 | Clock run-in pulse count from the external counter |
| line_end | input | 1 | End-of-slice-line pulse |
| irq_sel | input | 2 | Interrupt source select |
| data_clk | output | 1 | Data-clock enable pulse |
| byte_hi | output | 8 | Captured bits 15..8 |
| byte_lo | output | 8 | Captured bits 7..0 |
| latch_done | output | 1 | Latch-complete flag |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench measures the start-to-first-clock delay at the smallest and largest N. An off-by-one counter load would move that pulse by a cycle. Back-to-back spacing (`bit_per` = 1) catches a sequencer that emits a seventeenth pulse or drops the last one. The run-in window is probed at counts 3, 5 and 7, so a window that is too wide or too narrow sets the flag on the wrong line. Extra start pulses mid-capture and after completion, repeated end-of-line pulses, and a vertical sync fall in the middle of a capture expose designs that restart the clock, raise a second request, or keep stale bytes.

// File: rtl/cc_cap_pkg.sv
package cc_cap_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ACTIVE = 2'd1,
    SQ_DONE   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    IRQ_LINE_END  = 2'b00,
    IRQ_CAP_DONE  = 2'b01,
    IRQ_CAP_QUAL  = 2'b10,
    IRQ_DISABLED  = 2'b11
  } irq_src_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cc_dclk_seq.sv
module cc_dclk_seq
  import cc_cap_pkg::*;
#(
  parameter int unsigned DLY_W  = 5,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned BASE   = 13,
  parameter int unsigned PULSES = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             start,
  input  logic [DLY_W-1:0] dly_n,
  input  logic [PER_W-1:0] bit_per,
  output logic             fire,
  output logic             last,
  output logic             data_clk
);

  localparam int unsigned DLY_MAX = BASE + (1 << DLY_W);
  localparam int unsigned CNT_W   = max_u($clog2(DLY_MAX), PER_W);
  localparam int unsigned PCNT_W  = $clog2(PULSES + 1);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PCNT_W-1:0]  pcnt_q;
  logic [CNT_W-1:0]   per_m1;
  logic [CNT_W-1:0]   dly_load;

  // spacing of zero behaves as back-to-back pulses
  assign per_m1   = (bit_per == '0) ? '0 : CNT_W'(bit_per) - CNT_W'(1);
  assign dly_load = CNT_W'(BASE - 1) + CNT_W'(dly_n);

  assign fire = (state_q == SQ_ACTIVE) && (cnt_q == '0);
  assign last = fire && (pcnt_q == PCNT_W'(PULSES - 1));

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      pcnt_q   <= '0;
      data_clk <= 1'b0;
    end else begin
      data_clk <= fire;
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q <= SQ_ACTIVE;
            cnt_q   <= dly_load;
          end
        end
        SQ_ACTIVE: begin
          if (fire) begin
            if (last) begin
              state_q <= SQ_DONE;
            end else begin
              cnt_q  <= per_m1;
              pcnt_q <= pcnt_q + PCNT_W'(1);
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: begin
          state_q <= SQ_DONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/cc_shift_cap.sv
module cc_shift_cap #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              din,
  output logic [HALF_W-1:0] hi,
  output logic [HALF_W-1:0] lo
);

  logic [DATA_W-1:0] sr_q;

  // new bit enters at the top, so the first bit ends in bit 0
  always_ff @(posedge clk) begin
    if (clr) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= {din, sr_q[DATA_W-1:1]};
    end
  end

  assign hi = sr_q[DATA_W-1:HALF_W];
  assign lo = sr_q[HALF_W-1:0];

endmodule

// File: rtl/cc_done_irq.sv
module cc_done_irq
  import cc_cap_pkg::*;
#(
  parameter int unsigned RC_W  = 3,
  parameter int unsigned RC_LO = 4,
  parameter int unsigned RC_HI = 6
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            last,
  input  logic            method2,
  input  logic            qual_en,
  input  logic [RC_W-1:0] runin_cnt,
  input  logic            line_end,
  input  logic [1:0]      irq_sel,
  output logic            latch_done,
  output logic            irq
);

  logic     rc_ok;
  logic     qual_pass;
  logic     src;
  logic     fired_q;
  irq_src_e sel;

  assign sel       = irq_src_e'(irq_sel);
  assign rc_ok     = (runin_cnt >= RC_W'(RC_LO)) && (runin_cnt <= RC_W'(RC_HI));
  assign qual_pass = method2 | ~qual_en | rc_ok;

  always_comb begin
    case (sel)
      IRQ_LINE_END: src = line_end;
      IRQ_CAP_DONE: src = last;
      IRQ_CAP_QUAL: src = last & rc_ok;
      default:      src = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      latch_done <= 1'b0;
      irq        <= 1'b0;
      fired_q    <= 1'b0;
    end else begin
      irq     <= src & ~fired_q;
      fired_q <= fired_q | src;
      if (last && qual_pass) begin
        latch_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cc_line_capture.sv
module cc_line_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DLY_W  = 5,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned BASE   = 13,
  parameter int unsigned RC_W   = 3,
  parameter int unsigned RC_LO  = 4,
  parameter int unsigned RC_HI  = 6,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync,
  input  logic              start_det,
  input  logic              slice_bit,
  input  logic [DLY_W-1:0]  dly_sel,
  input  logic [PER_W-1:0]  bit_per,
  input  logic              method2,
  input  logic              qual_en,
  input  logic [RC_W-1:0]   runin_cnt,
  input  logic              line_end,
  input  logic [1:0]        irq_sel,
  output logic              data_clk,
  output logic [HALF_W-1:0] byte_hi,
  output logic [HALF_W-1:0] byte_lo,
  output logic              latch_done,
  output logic              irq
);

  logic vs_q;
  logic vs_fall;
  logic clr;
  logic fire;
  logic last;

  // high after reset, so a low vsync at release clears an already clear block
  always_ff @(posedge clk) begin
    if (rst) vs_q <= 1'b1;
    else     vs_q <= vsync;
  end

  assign vs_fall = vs_q & ~vsync;
  assign clr     = rst | vs_fall;

  cc_dclk_seq #(
    .DLY_W (DLY_W),
    .PER_W (PER_W),
    .BASE  (BASE),
    .PULSES(DATA_W)
  ) u_seq (
    .clk     (clk),
    .clr     (clr),
    .start   (start_det),
    .dly_n   (dly_sel),
    .bit_per (bit_per),
    .fire    (fire),
    .last    (last),
    .data_clk(data_clk)
  );

  cc_shift_cap #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk     (clk),
    .clr     (clr),
    .shift_en(fire),
    .din     (slice_bit),
    .hi      (byte_hi),
    .lo      (byte_lo)
  );

  cc_done_irq #(
    .RC_W (RC_W),
    .RC_LO(RC_LO),
    .RC_HI(RC_HI)
  ) u_done (
    .clk       (clk),
    .clr       (clr),
    .last      (last),
    .method2   (method2),
    .qual_en   (qual_en),
    .runin_cnt (runin_cnt),
    .line_end  (line_end),
    .irq_sel   (irq_sel),
    .latch_done(latch_done),
    .irq       (irq)
  );

endmodule

// File: rtl/cc_line_capture_chk.sv
module cc_line_capture_chk #(
  parameter int unsigned PULSES = 16,
  parameter int unsigned HALF_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              vsync,
  input logic              data_clk,
  input logic [HALF_W-1:0] byte_hi,
  input logic [HALF_W-1:0] byte_lo,
  input logic              latch_done,
  input logic              irq
);

  logic     vs_d;
  logic     fall_now;
  int unsigned dc_seen;
  int unsigned irq_seen;

  always_ff @(posedge clk) begin
    if (rst) vs_d <= 1'b1;
    else     vs_d <= vsync;
  end

  assign fall_now = vs_d & ~vsync;

  always_ff @(posedge clk) begin
    if (rst || fall_now) begin
      dc_seen  <= 0;
      irq_seen <= 0;
    end else begin
      if (data_clk) dc_seen  <= dc_seen + 1;
      if (irq)      irq_seen <= irq_seen + 1;
    end
  end

  assert_fall_clears_R7: assert property (@(posedge clk) disable iff (rst)
    fall_now |=> (byte_hi == '0 && byte_lo == '0 && !latch_done && !data_clk));

  assert_pulse_limit_R2: assert property (@(posedge clk) disable iff (rst)
    dc_seen <= PULSES);

  assert_bytes_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!data_clk && !$past(fall_now)) |-> $stable({byte_hi, byte_lo}));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_once_R6: assert property (@(posedge clk) disable iff (rst)
    irq_seen <= 1);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (latch_done && !fall_now) |=> latch_done);

endmodule

bind cc_line_capture cc_line_capture_chk #(
  .PULSES(DATA_W),
  .HALF_W(HALF_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .vsync     (vsync),
  .data_clk  (data_clk),
  .byte_hi   (byte_hi),
  .byte_lo   (byte_lo),
  .latch_done(latch_done),
  .irq       (irq)
);

// File: tb/cc_line_capture_bench.sv
`timescale 1ns/1ps
module cc_line_capture_bench;

  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vsync = 1'b1;
  logic       start_det = 1'b0;
  logic       slice_bit;
  logic [4:0] dly_sel = '0;
  logic [7:0] bit_per = 8'd1;
  logic       method2 = 1'b1;
  logic       qual_en = 1'b0;
  logic [2:0] runin_cnt = '0;
  logic       line_end = 1'b0;
  logic [1:0] irq_sel = 2'b11;
  logic       data_clk;
  logic [7:0] byte_hi;
  logic [7:0] byte_lo;
  logic       latch_done;
  logic       irq;

  logic        rand_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int dc_total  = 0;
  int irq_total = 0;

  // behavioural reference state
  bit          m_active, m_done, m_flag, m_irq, m_fired, m_dclk, m_vs_prev;
  logic [15:0] m_sh;
  int          m_next, m_pulses;

  always #10 clk = ~clk;

  assign slice_bit = rand_mode ? lfsr[0] : 1'b1;

  cc_line_capture u_cc_line_capture (
    .clk(clk), .rst(rst), .vsync(vsync), .start_det(start_det),
    .slice_bit(slice_bit), .dly_sel(dly_sel), .bit_per(bit_per),
    .method2(method2), .qual_en(qual_en), .runin_cnt(runin_cnt),
    .line_end(line_end), .irq_sel(irq_sel), .data_clk(data_clk),
    .byte_hi(byte_hi), .byte_lo(byte_lo), .latch_done(latch_done), .irq(irq)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // reference model, evaluated on each rising edge from the inputs
  always @(posedge clk) begin
    bit fall, evt_last, rc_ok, src;
    int per;
    cyc++;
    m_dclk = 0;
    m_irq  = 0;
    if (rst) begin
      m_active = 0; m_done = 0; m_flag = 0; m_fired = 0;
      m_sh = '0; m_pulses = 0; m_vs_prev = 1;
    end else begin
      fall = m_vs_prev && !vsync;
      m_vs_prev = vsync;
      if (fall) begin
        m_active = 0; m_done = 0; m_flag = 0; m_fired = 0;
        m_sh = '0; m_pulses = 0;
      end else begin
        evt_last = 0;
        if (m_active && cyc == m_next) begin
          m_dclk = 1;
          m_sh = {slice_bit, m_sh[15:1]};
          m_pulses++;
          if (m_pulses == 16) begin
            m_active = 0; m_done = 1; evt_last = 1;
          end else begin
            per = (bit_per == 0) ? 1 : int'(bit_per);
            m_next = cyc + per;
          end
        end else if (!m_active && !m_done && start_det) begin
          m_active = 1;
          m_next = cyc + 13 + int'(dly_sel);
        end
        rc_ok = (runin_cnt >= 4) && (runin_cnt <= 6);
        if (evt_last && (method2 || !qual_en || rc_ok)) m_flag = 1;
        case (irq_sel)
          2'b00:   src = line_end;
          2'b01:   src = evt_last;
          2'b10:   src = evt_last && rc_ok;
          default: src = 0;
        endcase
        if (src && !m_fired) begin
          m_irq = 1;
          m_fired = 1;
        end
      end
    end
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d expected below %0d cycles", cyc, WD_LIMIT);
      report();
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (data_clk) dc_total++;
    if (irq) irq_total++;
    check("R2", "data_clk", int'(data_clk), int'(m_dclk));
    check("R3", "byte_hi", int'(byte_hi), int'(m_sh[15:8]));
    check("R3", "byte_lo", int'(byte_lo), int'(m_sh[7:0]));
    check("R5", "latch_done", int'(latch_done), int'(m_flag));
    check("R6", "irq", int'(irq), int'(m_irq));
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic new_line();
    vsync = 1'b1;
    step();
    vsync = 1'b0;
    step();
    check("R7", "bytes after vsync fall", int'({byte_hi, byte_lo}), 0);
    check("R7", "flag after vsync fall", int'(latch_done), 0);
  endtask

  // start a capture and measure the delay to the first data clock (R1)
  task automatic start_and_time(input int n);
    int waited;
    dly_sel   = 5'(n);
    start_det = 1'b1;
    step();
    start_det = 1'b0;
    waited = 1;
    while (!data_clk && waited < 200) begin
      step();
      waited++;
    end
    check("R1", "start to first data clock", waited, 14 + n);
  endtask

  task automatic cfg(input int p, input bit m2, input bit q, input int rc, input int sel);
    bit_per   = 8'(p);
    method2   = m2;
    qual_en   = q;
    runin_cnt = 3'(rc);
    irq_sel   = 2'(sel);
  endtask

  initial begin
    int dc0, irq0;
    repeat (5) step();
    check("R9", "data_clk in reset", int'(data_clk), 0);
    check("R9", "bytes in reset", int'({byte_hi, byte_lo}), 0);
    check("R9", "flag and irq in reset", int'({latch_done, irq}), 0);
    rst = 1'b0;
    step();

    // line 1: method 2, spacing 3, constant ones
    new_line();
    cfg(3, 1, 1, 0, 1);
    rand_mode = 1'b0;
    dc0 = dc_total; irq0 = irq_total;
    start_and_time(0);
    repeat (16 * 3 + 6) step();
    check("R2", "pulse count", dc_total - dc0, 16);
    check("R3", "captured word", int'({byte_hi, byte_lo}), 16'hFFFF);
    check("R4", "flag under method 2", int'(latch_done), 1);
    check("R6", "irq on completion", irq_total - irq0, 1);
    start_det = 1'b1; step(); start_det = 1'b0;
    repeat (80) step();
    check("R8", "start after completion ignored", dc_total - dc0, 16);
    check("R10", "flag held", int'(latch_done), 1);

    // line 2: longest delay, back-to-back clocks, run-in 5 qualifies
    new_line();
    cfg(1, 0, 1, 5, 2);
    rand_mode = 1'b1;
    dc0 = dc_total; irq0 = irq_total;
    start_and_time(31);
    repeat (24) step();
    check("R2", "pulse count back-to-back", dc_total - dc0, 16);
    check("R5", "flag with run-in 5", int'(latch_done), 1);
    check("R6", "qualified irq", irq_total - irq0, 1);

    // line 3: run-in 3 fails window, extra start mid-capture
    new_line();
    cfg(2, 0, 1, 3, 2);
    dc0 = dc_total; irq0 = irq_total;
    start_and_time(7);
    repeat (6) step();
    start_det = 1'b1; step(); start_det = 1'b0;
    repeat (40) step();
    check("R8", "start during capture ignored", dc_total - dc0, 16);
    check("R5", "flag with run-in 3", int'(latch_done), 0);
    check("R6", "no qualified irq", irq_total - irq0, 0);

    // line 4: run-in 7 above window
    new_line();
    cfg(2, 0, 1, 7, 2);
    start_and_time(3);
    repeat (40) step();
    check("R5", "flag with run-in 7", int'(latch_done), 0);

    // line 5: method 1 without qualification, source disabled
    new_line();
    cfg(4, 0, 0, 0, 3);
    irq0 = irq_total;
    start_and_time(12);
    repeat (70) step();
    check("R4", "flag unqualified", int'(latch_done), 1);
    check("R6", "disabled source", irq_total - irq0, 0);

    // line 6: bit_per of zero acts as one
    new_line();
    cfg(0, 1, 1, 0, 1);
    dc0 = dc_total;
    start_and_time(1);
    repeat (24) step();
    check("R2", "pulse count spacing 0", dc_total - dc0, 16);

    // line 7: end-of-line source, two pulses give one request
    new_line();
    cfg(2, 1, 0, 0, 0);
    irq0 = irq_total;
    line_end = 1'b1; step(); line_end = 1'b0;
    repeat (3) step();
    line_end = 1'b1; step(); line_end = 1'b0;
    repeat (3) step();
    check("R6", "one end-of-line irq", irq_total - irq0, 1);

    // line 8: vsync fall in the middle of a capture
    new_line();
    cfg(2, 1, 0, 0, 1);
    dc0 = dc_total;
    start_and_time(0);
    repeat (10) step();
    vsync = 1'b1; step();
    vsync = 1'b0; step();
    check("R7", "bytes cleared mid-capture", int'({byte_hi, byte_lo}), 0);
    dc0 = dc_total;
    repeat (50) step();
    check("R7", "clock stopped after clear", dc_total - dc0, 0);

    report();
  end

endmodule